// File: doc/BRIEF.md
# Clock-Style Eviction Victim Selector

This block picks which of a fixed pool of memory frames should be given up when a new page has to be brought in. The frames form a ring, and each carries a single "recently used" flag. Any access to a frame raises its flag through an access input. When the surrounding logic asks for a victim, a leading pointer sweeps around the ring. It starts one position past the frame chosen last time. Every raised flag it meets is lowered, and it moves on one frame per cycle. The first frame whose flag is already low becomes the victim. The victim is reported with a one-cycle pulse and remembered as the new resume point.

An optional second pointer can be switched on. It trails the leading pointer by a programmable number of frames around the ring. In every sweep cycle it reports, as an eviction candidate, the frame under it when that frame's flag is still low. Such a frame was not touched again after the leading pointer lowered its flag, or was never touched at all. Neither frame contents nor transfers to backing storage are handled here.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset no sweep is in progress, `done`, `busy` and `evict_valid` are 0, every flag is 0, the resume point is frame N-1 (so the first sweep begins at frame 0), and the trailing distance is 1.
- R2: A sweep begins at the frame one past the last victim, wrapping from frame N-1 to frame 0.
- R3: While sweeping, a frame whose flag is 1 has its flag lowered and the pointer advances by exactly one frame in that cycle.
- R4: When the frame under the pointer has flag 0, `done` is high for exactly one cycle on the next clock with `victim_idx` equal to that frame, `busy` drops, and that frame becomes the resume point.
- R5: `acc_valid` with `acc_idx` raises that frame's flag on the next clock; if the sweep lowers the same frame's flag in that cycle, the flag ends up raised.
- R6: With `two_hand_en` high, in every sweep cycle the trailing position is (leading position − distance) mod N; if that frame's flag is 0, `evict_valid` pulses on the next clock with `evict_idx` equal to it. With `two_hand_en` low, `evict_valid` stays 0.
- R7: With no accesses during a sweep, `done` rises at most N+1 clocks after the clock that accepted `req`.
- R8: `dist_we` loads `dist_val` into the trailing distance only if the value lies in 1..N-1; a write of 0 leaves the distance unchanged.
- R9: `req` is accepted only while `busy` is 0; a request during a sweep neither restarts it nor queues a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | A frame was accessed this cycle |
| acc_idx | input | IDX_W | Index of the accessed frame |
| req | input | 1 | Request a victim (taken when idle) |
| two_hand_en | input | 1 | Enable trailing-pointer reports |
| dist_we | input | 1 | Load the trailing distance |
| dist_val | input | IDX_W | New trailing distance |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle victim pulse |
| victim_idx | output | IDX_W | Chosen frame, valid with `done` |
| evict_valid | output | 1 | Trailing pointer found an unreferenced frame |
| evict_idx | output | IDX_W | Frame reported by the trailing pointer |

## Verification
The bench targets the wrap from the last frame to frame 0. A design that resumed at the last victim itself, rather than one past it, would return the same frame twice. It also targets the worst case where every flag is raised, where an off-by-one sweep would need N+2 clocks or skip the start frame. An access that collides with the pointer clearing the same frame is checked as well: if the clear won, a later sweep would pick that frame instead of its neighbour. Finally the bench makes requests in mid-sweep and writes zero to the distance. A design that restarts or queues such a request stretches the latency or emits a second pulse. A design that takes the zero shifts every trailing report.

// File: rtl/clock_sel_pkg.sv
// Shared types for the clock-style victim selector.
package clock_sel_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SCAN = 1'b1
    } phase_e;
endpackage

// File: rtl/ref_flags.sv
// ref_flags: one "recently used" flag per frame.
// Assumes at most one set and one clear request per cycle; a set wins
// over a clear aimed at the same frame.
module ref_flags #(
    parameter int N_FRAMES = 16,
    localparam int IDX_W = $clog2(N_FRAMES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [IDX_W-1:0]    set_idx,
    input  logic                clr_en,
    input  logic [IDX_W-1:0]    clr_idx,
    output logic [N_FRAMES-1:0] flags
);
    for (genvar g = 0; g < N_FRAMES; g++) begin : g_flag
        // Per-frame flag update: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[g] <= 1'b0;
            else if (set_en && set_idx == IDX_W'(g))
                flags[g] <= 1'b1;
            else if (clr_en && clr_idx == IDX_W'(g))
                flags[g] <= 1'b0;
        end
    end

    // R5: a colliding access and clear leaves the flag raised
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && clr_en && set_idx == clr_idx) |=> flags[$past(set_idx)]);
    // R5: a lone access raises its flag
    a_r5_access_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> flags[$past(set_idx)]);
endmodule

// File: rtl/lead_hand.sv
// lead_hand: sweep controller. On an idle request it starts one frame past
// the resume point, lowers raised flags one frame per cycle, and stops on
// the first lowered flag, reporting it and storing it as the resume point.
// Assumes flags come from ref_flags with one cycle of write latency.
module lead_hand
    import clock_sel_pkg::*;
#(
    parameter int N_FRAMES = 16,
    localparam int IDX_W = $clog2(N_FRAMES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [N_FRAMES-1:0] flags,
    output logic                clr_en,
    output logic [IDX_W-1:0]    clr_idx,
    output logic                busy,
    output logic [IDX_W-1:0]    lead_pos,
    output logic                done,
    output logic [IDX_W-1:0]    victim_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_FRAMES - 1);

    phase_e           phase_q;
    logic [IDX_W-1:0] hand_q;
    logic [IDX_W-1:0] last_q;
    logic             hit_set;

    function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Decode the frame under the pointer.
    always_comb begin
        busy     = (phase_q == PH_SCAN);
        hit_set  = flags[hand_q];
        clr_en   = busy && hit_set;
        clr_idx  = hand_q;
        lead_pos = hand_q;
    end

    // Sweep state machine, pointer, resume point and victim report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            hand_q     <= '0;
            last_q     <= LAST;
            done       <= 1'b0;
            victim_idx <= '0;
        end else begin
            done <= 1'b0;
            if (phase_q == PH_IDLE) begin
                if (req) begin
                    phase_q <= PH_SCAN;
                    hand_q  <= ring_next(last_q);
                end
            end else if (hit_set) begin
                hand_q <= ring_next(hand_q);
            end else begin
                done       <= 1'b1;
                victim_idx <= hand_q;
                last_q     <= hand_q;
                phase_q    <= PH_IDLE;
            end
        end
    end

    // R2: a sweep starts one past the resume point
    a_r2_start_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req) |=> (busy && hand_q == ring_next($past(last_q))));
    // R3: a raised flag advances the pointer by one frame
    a_r3_hand_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hit_set) |=> (busy && hand_q == ring_next($past(hand_q))));
    // R4: the victim had a lowered flag when chosen
    a_r4_victim_was_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!$past(flags[hand_q]) && victim_idx == hand_q));
    // R4: done is a single-cycle pulse
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: a request mid-sweep does not move the pointer back
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hit_set && req) |=> hand_q == ring_next($past(hand_q)));
endmodule

// File: rtl/trail_hand.sv
// trail_hand: holds the trailing distance and, in two-pointer mode, reports
// the frame that distance behind the leading pointer when its flag is low.
// Assumes lead_pos and flags are the values seen by the sweep this cycle.
module trail_hand #(
    parameter int N_FRAMES = 16,
    localparam int IDX_W = $clog2(N_FRAMES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                two_hand_en,
    input  logic                dist_we,
    input  logic [IDX_W-1:0]    dist_val,
    input  logic                busy,
    input  logic [IDX_W-1:0]    lead_pos,
    input  logic [N_FRAMES-1:0] flags,
    output logic                evict_valid,
    output logic [IDX_W-1:0]    evict_idx
);
    localparam logic [IDX_W:0] NW = (IDX_W + 1)'(N_FRAMES);

    logic [IDX_W-1:0] dist_q;
    logic [IDX_W:0]   raw_pos;
    logic [IDX_W-1:0] trail_pos;
    logic             dist_ok;

    // Trailing position = lead - distance modulo the ring size.
    always_comb begin
        raw_pos   = {1'b0, lead_pos} + NW - {1'b0, dist_q};
        trail_pos = (raw_pos >= NW) ? IDX_W'(raw_pos - NW) : IDX_W'(raw_pos);
        dist_ok   = (dist_val != '0) && ({1'b0, dist_val} < NW);
    end

    // Distance register: only in-range, non-zero values are taken.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dist_q <= IDX_W'(1);
        else if (dist_we && dist_ok)
            dist_q <= dist_val;
    end

    // Candidate report, one clock after the sweep cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evict_valid <= 1'b0;
            evict_idx   <= '0;
        end else begin
            evict_valid <= two_hand_en && busy && !flags[trail_pos];
            evict_idx   <= trail_pos;
        end
    end

    // R8: the distance never leaves 1..N-1
    a_r8_dist_range: assert property (@(posedge clk) disable iff (!rst_n)
        (dist_q != '0) && ({1'b0, dist_q} < NW));
    // R6: reports only follow a two-pointer sweep cycle
    a_r6_only_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> $past(two_hand_en && busy));
    // R6: a reported frame had a lowered flag
    a_r6_reported_clear: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> !$past(flags[trail_pos]));
endmodule

// File: rtl/clock_victim_sel.sv
// clock_victim_sel: top of the clock-style victim selector. Joins the flag
// array, the leading sweep pointer and the optional trailing pointer.
// Assumes one access per cycle and that req is held or pulsed while idle.
module clock_victim_sel #(
    parameter int N_FRAMES = 16,
    localparam int IDX_W = $clog2(N_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic             req,
    input  logic             two_hand_en,
    input  logic             dist_we,
    input  logic [IDX_W-1:0] dist_val,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] victim_idx,
    output logic             evict_valid,
    output logic [IDX_W-1:0] evict_idx
);
    logic [N_FRAMES-1:0] flags;
    logic                clr_en;
    logic [IDX_W-1:0]    clr_idx;
    logic [IDX_W-1:0]    lead_pos;

    ref_flags #(.N_FRAMES(N_FRAMES)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_en(acc_valid), .set_idx(acc_idx),
        .clr_en(clr_en), .clr_idx(clr_idx),
        .flags(flags)
    );

    lead_hand #(.N_FRAMES(N_FRAMES)) u_lead (
        .clk(clk), .rst_n(rst_n), .req(req), .flags(flags),
        .clr_en(clr_en), .clr_idx(clr_idx), .busy(busy),
        .lead_pos(lead_pos), .done(done), .victim_idx(victim_idx)
    );

    trail_hand #(.N_FRAMES(N_FRAMES)) u_trail (
        .clk(clk), .rst_n(rst_n), .two_hand_en(two_hand_en),
        .dist_we(dist_we), .dist_val(dist_val), .busy(busy),
        .lead_pos(lead_pos), .flags(flags),
        .evict_valid(evict_valid), .evict_idx(evict_idx)
    );

    // R1: nothing is reported in the cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !evict_valid));
endmodule

// File: tb/clock_victim_sel_bench.sv
module clock_victim_sel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam int W = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0;
    logic [W-1:0] acc_idx = '0;
    logic req = 1'b0;
    logic two_hand_en = 1'b0;
    logic dist_we = 1'b0;
    logic [W-1:0] dist_val = '0;
    logic busy, done, evict_valid;
    logic [W-1:0] victim_idx, evict_idx;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    bit cmp_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clock_victim_sel #(.N_FRAMES(N)) u_clock_victim_sel (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(acc_idx),
        .req(req), .two_hand_en(two_hand_en), .dist_we(dist_we),
        .dist_val(dist_val), .busy(busy), .done(done), .victim_idx(victim_idx),
        .evict_valid(evict_valid), .evict_idx(evict_idx)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: flags, pointer and resume point as plain integers.
    bit m_flag[N];
    bit m_busy, m_done, m_ev;
    int m_hand, m_last, m_dist, m_vic, m_evi;

    always @(posedge clk) begin : model
        bit n_done, n_ev;
        int t;
        if (!rst_n) begin
            foreach (m_flag[i]) m_flag[i] = 1'b0;
            m_busy = 0; m_done = 0; m_ev = 0;
            m_hand = 0; m_last = N - 1; m_dist = 1; m_vic = 0; m_evi = 0;
        end else begin
            n_done = 0; n_ev = 0;
            if (m_busy) begin
                t = (m_hand + N - m_dist) % N;
                n_ev = two_hand_en && !m_flag[t];
                m_evi = t;
                if (m_flag[m_hand]) begin
                    m_flag[m_hand] = 1'b0;
                    m_hand = (m_hand + 1) % N;
                end else begin
                    n_done = 1; m_vic = m_hand; m_last = m_hand; m_busy = 0;
                end
            end else if (req) begin
                m_busy = 1;
                m_hand = (m_last + 1) % N;
            end
            if (acc_valid) m_flag[acc_idx] = 1'b1;
            if (dist_we && dist_val != 0) m_dist = int'(dist_val);
            m_done = n_done;
            m_ev = n_ev;
        end
    end

    // Per-cycle comparison against the reference, away from the clock edge.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check(busy == m_busy, "R9 busy vs model", busy, m_busy);
            check(done == m_done, "R4 done vs model", done, m_done);
            if (m_done) check(victim_idx == W'(m_vic), "R4 victim vs model", victim_idx, m_vic);
            check(evict_valid == m_ev, "R6 evict_valid vs model", evict_valid, m_ev);
            if (m_ev) check(evict_idx == W'(m_evi), "R6 evict_idx vs model", evict_idx, m_evi);
        end
    end

    task automatic touch(input int f);
        acc_valid = 1'b1; acc_idx = W'(f);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    int ev_q[$];

    // Pulse req; optional access on the first sweep cycle and a mid-sweep req.
    task automatic sweep(output int lat, output int vic, input int hit_acc, input bit mid_req);
        ev_q.delete();
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        if (hit_acc >= 0) begin acc_valid = 1'b1; acc_idx = W'(hit_acc); end
        lat = 0; vic = -1;
        while (lat < 3 * N) begin
            @(negedge clk);
            acc_valid = 1'b0;
            req = (mid_req && lat == 4);
            lat++;
            if (evict_valid) ev_q.push_back(int'(evict_idx));
            if (done) begin vic = int'(victim_idx); break; end
        end
        req = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int lat, vic, extra;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        check(!busy && !done && !evict_valid, "R1 reset outputs", {busy, done, evict_valid}, 0);

        // R1: empty ring, resume point N-1 -> frame 0 in one clock
        sweep(lat, vic, -1, 0);
        check(vic == 0, "R1 first victim", vic, 0);
        check(lat == 1, "R1 first latency", lat, 1);

        // R2/R3: frames 1,2 raised -> both cleared, victim 3
        touch(1); touch(2);
        sweep(lat, vic, -1, 0);
        check(vic == 3, "R2 resume after last victim", vic, 3);
        check(lat == 3, "R3 one frame per clock", lat, 3);

        // R7: all raised -> full revolution, victim is the start frame 4
        for (int i = 0; i < N; i++) touch(i);
        sweep(lat, vic, -1, 0);
        check(vic == 4, "R7 full revolution victim", vic, 4);
        check(lat == N + 1, "R7 worst-case latency", lat, N + 1);

        // R5: access to frame 5 while the pointer clears it
        touch(5); touch(6);
        sweep(lat, vic, 5, 0);
        check(vic == 7, "R5 collision sweep victim", vic, 7);
        for (int i = 0; i < N; i++) if (i < 5 || i > 7) touch(i);
        sweep(lat, vic, -1, 0);
        check(vic == 6, "R5 collided flag stayed raised", vic, 6);
        check(lat == 15, "R5 latency with kept flag", lat, 15);

        // R9: second req mid-sweep is ignored
        for (int i = 0; i < N; i++) touch(i);
        sweep(lat, vic, -1, 1);
        check(vic == 7, "R9 victim with mid-sweep req", vic, 7);
        check(lat == N + 1, "R9 latency with mid-sweep req", lat, N + 1);
        extra = 0;
        repeat (2 * N) begin @(negedge clk); if (done || busy) extra++; end
        check(extra == 0, "R9 no queued sweep", extra, 0);

        // R6/R8: distance 3, then an ignored write of 0
        dist_we = 1'b1; dist_val = W'(3); @(negedge clk);
        dist_val = '0; @(negedge clk);
        dist_we = 1'b0;
        two_hand_en = 1'b1;
        for (int i = 5; i <= 12; i++) if (i == 5 || i >= 8) touch(i);
        sweep(lat, vic, -1, 0);
        check(vic == 13, "R6 two-hand victim", vic, 13);
        check(ev_q.size() == 5, "R6 report count", ev_q.size(), 5);
        if (ev_q.size() == 5) begin
            check(ev_q[0] == 6, "R8 zero write ignored, first report", ev_q[0], 6);
            check(ev_q[4] == 10, "R6 last report", ev_q[4], 10);
        end

        // Mixed traffic, compared against the model every clock.
        for (int c = 0; c < 4000; c++) begin
            acc_valid = ($urandom_range(0, 2) == 0);
            acc_idx = W'($urandom_range(0, N - 1));
            req = ($urandom_range(0, 5) == 0);
            dist_we = ($urandom_range(0, 30) == 0);
            dist_val = W'($urandom_range(0, N - 1));
            if ($urandom_range(0, 200) == 0) two_hand_en = ~two_hand_en;
            @(negedge clk);
        end
        acc_valid = 1'b0; req = 1'b0; dist_we = 1'b0;
        repeat (2 * N + 4) @(negedge clk);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule